// File: doc/BRIEF.md
# Word-to-Quadword Packing Write Bridge

This bridge sits between a 32-bit streaming source and a 128-bit memory write port. It takes words on a valid/ready/last handshake and gathers them into lanes of a quadword, with the earliest word in the lowest lane. Once four words are gathered, or the stream ends early, it issues the quadword as one write. Each write carries a fixed master ID and goes to an address that starts at a base parameter and moves up one quadword per write.

When the word flagged last has been packed and its write issued, the bridge raises a sticky completion output. Downstream handshake logic can use this as a "payload has fully landed" condition. The bridge is one-shot: after completion it refuses further input until reset.

Control is a three-state machine. In GATHER the input is ready and each accepted word fills the next lane. GATHER goes to ISSUE when the accepted word fills the top lane or carries last. ISSUE drives the write for exactly one cycle with the input held off. From ISSUE the machine returns to GATHER (lanes cleared, address advanced) when no last was taken. It moves to DONE when a last was taken. DONE is terminal until reset.

Top module: `qword_pack_bridge`

## Requirements
- R1: Word k of a quadword (k = 0..3, in arrival order) is placed in write data bits [32k+31:32k]; word 0 is in bits 31:0 and word 3 in bits 127:96.
- R2: The first write goes to BASE_ADDR (default 0x100), and each following write goes 16 bytes above the previous one.
- R3: A quadword with all four lanes filled is written with byte-enable 16'hFFFF, and every write carries master ID MASTER_ID (default 5).
- R4: The input ready is low for the one cycle in which a write is issued, so the source is held off and no word is taken during that cycle.
- R5: Each write lasts exactly one cycle, and a stream of N words produces exactly ceil(N/4) writes (16 words give 4 writes).
- R6: When last arrives with fewer than four lanes filled, the partial quadword is written with byte-enable bits [4k+3:4k] set only for filled lanes k, and unfilled lanes hold zero data.
- R7: The completion output is low during the final write and goes high in the cycle right after it, then stays high until reset.
- R8: After completion, the input ready stays low and further valid input causes no write.
- R9: Reset clears the lane counter, the address offset and the completion output: afterwards the input is ready, no write is pending, and the next write goes to BASE_ADDR with a fresh lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word valid |
| in_data | input | 32 | Source word |
| in_last | input | 1 | Marks the final word of the stream |
| in_ready | output | 1 | Bridge can take a word this cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 32 | Destination byte address |
| wr_data | output | 128 | Packed quadword |
| wr_be | output | 16 | Byte enables, one per data byte |
| wr_master_id | output | 8 | Master ID tagged on each write |
| last_seen | output | 1 | Sticky completion flag |

## Verification
On every cycle, the assertions check that a write never overlaps an accepted word, that writes are single-cycle pulses, and that addresses stay on quadword steps from the base. They also check that byte enables form a contiguous low run, that a partial write is always the final one, and that completion follows the final write, stays set and silences the block. What the assertions cannot see are the values themselves. The lane order of the packed data, the exact address sequence, the write count for a given stream length, the stall count under back-to-back input and the clearing effect of a mid-stream reset are shown only by the bench's directed scenarios.

// File: rtl/qpk_pkg.sv
package qpk_pkg;
    typedef enum logic [1:0] {
        QP_GATHER = 2'd0,
        QP_ISSUE  = 2'd1,
        QP_DONE   = 2'd2
    } qp_state_e;
endpackage

// File: rtl/qpk_lane_gather.sv
module qpk_lane_gather #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int LINE_W = WORD_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    input  logic              clear,
    output logic [LINE_W-1:0] line,
    output logic [LANES-1:0]  fill,
    output logic              at_top
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (take && (idx_q != IDX_W'(LANES - 1))) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign at_top = (idx_q == IDX_W'(LANES - 1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] word_q;
        logic              fill_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                word_q <= '0;
                fill_q <= 1'b0;
            end else if (take && (idx_q == IDX_W'(g))) begin
                word_q <= word;
                fill_q <= 1'b1;
            end
        end
        assign line[g*WORD_W +: WORD_W] = word_q;
        assign fill[g]                  = fill_q;
    end
endmodule

// File: rtl/qpk_addr_step.sv
module qpk_addr_step #(
    parameter int                ADDR_W    = 32,
    parameter int                STEP      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (advance) begin
            offset_q <= offset_q + ADDR_W'(STEP);
        end
    end

    assign addr = BASE_ADDR + offset_q;
endmodule

// File: rtl/qpk_ctrl.sv
module qpk_ctrl
    import qpk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic lane_top,
    output logic in_ready,
    output logic take,
    output logic issue,
    output logic done
);
    qp_state_e state_q, state_d;
    logic      last_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= QP_GATHER;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take && in_last) begin
                last_q <= 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QP_GATHER: if (in_valid && (in_last || lane_top)) state_d = QP_ISSUE;
            QP_ISSUE:  state_d = last_q ? QP_DONE : QP_GATHER;
            QP_DONE:   state_d = QP_DONE;
            default:   state_d = QP_GATHER;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        issue    = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            QP_GATHER: in_ready = 1'b1;
            QP_ISSUE:  issue    = 1'b1;
            QP_DONE:   done     = 1'b1;
            default:   in_ready = 1'b0;
        endcase
        take = in_valid && in_ready;
    end
endmodule

// File: rtl/qword_pack_bridge.sv
module qword_pack_bridge #(
    parameter int                WORD_W    = 32,
    parameter int                LANES     = 4,
    parameter int                ADDR_W    = 32,
    parameter int                ID_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0100,
    parameter logic [ID_W-1:0]   MASTER_ID = 8'd5,
    localparam int LINE_W = WORD_W * LANES,
    localparam int BE_W   = LINE_W / 8,
    localparam int BPW    = WORD_W / 8,
    localparam int STEP   = BE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LINE_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be,
    output logic [ID_W-1:0]   wr_master_id,
    output logic              last_seen
);
    logic             take, issue, done, lane_top;
    logic [LANES-1:0] fill;

    qpk_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .lane_top (lane_top),
        .in_ready (in_ready),
        .take     (take),
        .issue    (issue),
        .done     (done)
    );

    qpk_lane_gather #(.WORD_W(WORD_W), .LANES(LANES)) u_gather (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .word   (in_data),
        .clear  (issue),
        .line   (wr_data),
        .fill   (fill),
        .at_top (lane_top)
    );

    qpk_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP), .BASE_ADDR(BASE_ADDR)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (issue),
        .addr    (wr_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_be
        assign wr_be[g*BPW +: BPW] = {BPW{fill[g]}};
    end

    assign wr_en        = issue;
    assign wr_master_id = MASTER_ID;
    assign last_seen    = done;
endmodule

// File: rtl/qpk_checker.sv
module qpk_checker #(
    parameter int                BE_W      = 16,
    parameter int                ADDR_W    = 32,
    parameter int                STEP      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BE_W-1:0]   wr_be,
    input logic              last_seen
);
    logic [ADDR_W-1:0] rel;
    logic [BE_W-1:0]   be_inc;
    assign rel    = wr_addr - BASE_ADDR;
    assign be_inc = wr_be + BE_W'(1);

    a_r4_no_take_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);
    a_r5_one_cycle_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    a_r2_step_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((rel & ADDR_W'(STEP - 1)) == '0));
    a_r6_contiguous_be: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be != '0) && $onehot0(be_inc));
    a_r6_partial_is_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_be != '1)) |=> last_seen);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        last_seen |=> last_seen);
    a_r7_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(last_seen) |-> $past(wr_en));
    a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        last_seen |-> (!in_ready && !wr_en));
endmodule

bind qword_pack_bridge qpk_checker #(
    .BE_W      (BE_W),
    .ADDR_W    (ADDR_W),
    .STEP      (STEP),
    .BASE_ADDR (BASE_ADDR)
) u_qpk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .last_seen (last_seen)
);

// File: tb/sim_qword_pack_bridge.sv
`timescale 1ns/1ps
module sim_qword_pack_bridge;
    localparam logic [31:0] BASE = 32'h0000_0100;
    localparam logic [7:0]  MID  = 8'd5;

    logic         clk, rst_n;
    logic         in_valid, in_last, in_ready;
    logic [31:0]  in_data;
    logic         wr_en, last_seen;
    logic [31:0]  wr_addr;
    logic [127:0] wr_data;
    logic [15:0]  wr_be;
    logic [7:0]   wr_master_id;

    qword_pack_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_master_id(wr_master_id), .last_seen(last_seen)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int n_wr    = 0;
    int stall_cnt = 0;
    logic [31:0]  log_addr [16];
    logic [127:0] log_data [16];
    logic [15:0]  log_be   [16];
    logic [7:0]   log_id   [16];
    logic         log_ls   [16];

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (n_wr < 16) begin
                log_addr[n_wr] = wr_addr;
                log_data[n_wr] = wr_data;
                log_be[n_wr]   = wr_be;
                log_id[n_wr]   = wr_master_id;
                log_ls[n_wr]   = last_seen;
            end
            n_wr = n_wr + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [15:0] seed, input int k);
        return {seed, 16'(k)};
    endfunction

    function automatic logic [127:0] exp_q(input logic [15:0] seed, input int q, input int n);
        logic [127:0] v = '0;
        for (int l = 0; l < 4; l++)
            if (q*4 + l < n) v[l*32 +: 32] = word_of(seed, q*4 + l);
        return v;
    endfunction

    function automatic logic [15:0] exp_be(input int q, input int n);
        logic [15:0] v = '0;
        for (int l = 0; l < 4; l++)
            if (q*4 + l < n) v[l*4 +: 4] = 4'hF;
        return v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_wr = 0;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d, input bit last);
        in_valid = 1'b1; in_data = d; in_last = last;
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_stream(input int n, input logic [15:0] seed);
        for (int k = 0; k < n; k++) push(word_of(seed, k), k == n - 1);
        idle();
        repeat (3) @(negedge clk);
    endtask

    task automatic verify_stream(input int n, input logic [15:0] seed);
        int nq = (n + 3) / 4;
        check(n_wr == nq, "R5 write count", 128'(n_wr), 128'(nq));
        for (int q = 0; q < nq && q < 16; q++) begin
            check(log_addr[q] == BASE + 32'(16*q), "R2 address", 128'(log_addr[q]), 128'(BASE + 32'(16*q)));
            check(log_data[q] == exp_q(seed, q, n), "R1 packing", log_data[q], exp_q(seed, q, n));
            check(log_be[q] == exp_be(q, n), "R3/R6 byte enable", 128'(log_be[q]), 128'(exp_be(q, n)));
            check(log_id[q] == MID, "R3 master id", 128'(log_id[q]), 128'(MID));
            check(log_ls[q] == 1'b0, "R7 low during write", 128'(log_ls[q]), 128'(0));
        end
        check(last_seen == 1'b1, "R7 completion set", 128'(last_seen), 128'(1));
    endtask

    task automatic t_reset();
        do_reset();
        check(last_seen == 1'b0, "R9 completion clear", 128'(last_seen), 128'(0));
        check(in_ready == 1'b1, "R9 ready after reset", 128'(in_ready), 128'(1));
        check(wr_en == 1'b0, "R9 no write after reset", 128'(wr_en), 128'(0));
    endtask

    task automatic t_full();
        do_reset();
        stall_cnt = 0;
        send_stream(16, 16'hA5C3);
        verify_stream(16, 16'hA5C3);
        check(stall_cnt == 3, "R4 stall per write", 128'(stall_cnt), 128'(3));
    endtask

    task automatic t_partial();
        do_reset();
        send_stream(6, 16'h3C01);
        verify_stream(6, 16'h3C01);
    endtask

    task automatic t_single_timing();
        do_reset();
        push(word_of(16'h7E00, 0), 1'b1);
        idle();
        check(wr_en == 1'b1, "R7 write cycle", 128'(wr_en), 128'(1));
        check(last_seen == 1'b0, "R7 not before write", 128'(last_seen), 128'(0));
        check(in_ready == 1'b0, "R4 ready low in write", 128'(in_ready), 128'(0));
        @(negedge clk);
        check(last_seen == 1'b1, "R7 rises after write", 128'(last_seen), 128'(1));
        check(wr_en == 1'b0, "R5 write one cycle", 128'(wr_en), 128'(0));
        repeat (2) @(negedge clk);
        verify_stream(1, 16'h7E00);
    endtask

    task automatic t_gaps();
        do_reset();
        for (int k = 0; k < 8; k++) begin
            push(word_of(16'h0B0B, k), k == 7);
            idle();
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        verify_stream(8, 16'h0B0B);
    endtask

    task automatic t_after_done();
        int seen_ready = 0;
        int wr_before;
        do_reset();
        send_stream(4, 16'h1111);
        wr_before = n_wr;
        in_valid = 1'b1; in_data = 32'hFFFF_0000; in_last = 1'b1;
        for (int c = 0; c < 6; c++) begin
            if (in_ready) seen_ready++;
            @(negedge clk);
        end
        idle();
        repeat (2) @(negedge clk);
        check(seen_ready == 0, "R8 ready stays low", 128'(seen_ready), 128'(0));
        check(n_wr == wr_before, "R8 no extra write", 128'(n_wr), 128'(wr_before));
        check(last_seen == 1'b1, "R7 sticky", 128'(last_seen), 128'(1));
    endtask

    task automatic t_reset_mid();
        do_reset();
        push(32'hDEAD_0001, 1'b0);
        push(32'hDEAD_0002, 1'b0);
        idle();
        @(negedge clk);
        do_reset();
        check(in_ready == 1'b1, "R9 ready after mid reset", 128'(in_ready), 128'(1));
        send_stream(4, 16'h4242);
        verify_stream(4, 16'h4242);
    endtask

    initial begin
        t_reset();
        t_full();
        t_partial();
        t_single_timing();
        t_gaps();
        t_after_done();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule